// File: doc/BRIEF.md
# One-bit rake channel estimator

This block learns the combined response of a transmitted pulse and the radio channel from a known training pulse train. The front end delivers one hard-limited sample for every time finger of the observation window after each pulse. The block keeps one signed up/down counter per finger and accumulates all fingers in parallel, one step per pulse. A finger steps up when its sample matches the known polarity of the current training pulse and steps down when it does not. No multiplier is needed anywhere.

A run begins with a start strobe. The strobe clears every finger and latches the number of training pulses to integrate. When that many pulses have been accepted, a done flag rises. The estimate then freezes, and a read port returns one finger per cycle by index. Downstream logic uses these values as its matched-filter template. The channel stays stationary for only about a millisecond, so the owner refreshes the estimate by issuing start again.

Top module: `rake_chan_est`

## Requirements
- R1: After reset done_o is 0, rd_data_o is 0, and every finger counter holds 0.
- R2: A start_i pulse clears every finger to 0 and drops done_o (unless the latched count is zero). If pulse_valid_i is high in the same cycle as start_i, that pulse is not integrated.
- R3: Finger counters are CNT_W-bit two's complement and saturate at +(2^(CNT_W-1)-1) and -2^(CNT_W-1), which is +63 and -64 for 7 bits. They never wrap.
- R4: During integration, each cycle with pulse_valid_i high moves every finger k by exactly one step. The step is +1 when samples_i[k] XOR polarity_i is 0 and -1 when it is 1. Cycles with pulse_valid_i low change nothing.
- R5: num_pulses_i is latched at start. done_o rises on the clock edge that accepts the num_pulses_i-th pulse, so it is visible in the following cycle. A latched count of 0 makes done_o rise on the edge after start.
- R6: While done_o is high, and before the first start, pulses do not change any finger. done_o stays high until the next start.
- R7: rd_data_o shows the finger selected by rd_idx_i one clock edge after the index is presented, in two's complement. It shows 0 whenever done_o was low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear fingers and begin a new integration |
| num_pulses_i | input | PULSE_CNT_W | Training pulses to integrate, latched at start |
| pulse_valid_i | input | 1 | One strobe per pulse repetition period |
| samples_i | input | NUM_FINGERS | One-bit sample per finger for this pulse |
| polarity_i | input | 1 | Known training polarity of this pulse |
| done_o | output | 1 | Estimate complete and frozen |
| rd_idx_i | input | IDX_W | Finger index to read |
| rd_data_o | output | CNT_W | Selected finger value, registered |

## Verification
Finger counters change on the same edge that samples a valid pulse. done_o is visible in the cycle after the edge that accepts the last pulse, and rd_data_o reflects the index presented before the preceding edge. The bench drives every input on the falling edge and samples the outputs at the next falling edge, so each result is read exactly one edge after its cause. It checks that done_o is still low just before the final pulse and high just after it. Frozen and ignored pulses are confirmed by reading the fingers back through the read port after those pulses.

// File: rtl/rake_est_pkg.sv
package rake_est_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_READY = 2'd2
  } est_state_e;
endpackage

// File: rtl/rake_finger.sv
module rake_finger #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             down_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CntMin = {1'b1, {(CNT_W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (en_i) begin
      if (down_i) begin
        if (cnt_o != CntMin) cnt_o <= cnt_o - 1'b1;
      end else begin
        if (cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rake_seq.sv
module rake_seq
  import rake_est_pkg::*;
#(
  parameter int PULSE_CNT_W = 11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [PULSE_CNT_W-1:0] num_pulses_i,
  input  logic                   pulse_valid_i,
  output logic                   upd_o,
  output logic                   busy_o,
  output logic                   done_o
);
  est_state_e             state_q;
  logic [PULSE_CNT_W-1:0] count_q;
  logic [PULSE_CNT_W-1:0] target_q;
  logic [PULSE_CNT_W-1:0] count_nxt;

  assign busy_o    = (state_q == ST_INTEG);
  assign done_o    = (state_q == ST_READY);
  assign upd_o     = busy_o && pulse_valid_i && !start_i;
  assign count_nxt = count_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      count_q  <= '0;
      target_q <= '0;
    end else if (start_i) begin
      count_q  <= '0;
      target_q <= num_pulses_i;
      state_q  <= (num_pulses_i == '0) ? ST_READY : ST_INTEG;
    end else if (upd_o) begin
      count_q <= count_nxt;
      if (count_nxt == target_q) state_q <= ST_READY;
    end
  end
endmodule

// File: rtl/rake_readout.sv
module rake_readout #(
  parameter int NUM_FINGERS = 64,
  parameter int CNT_W       = 7,
  parameter int IDX_W       = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         done_i,
  input  logic [IDX_W-1:0]             rd_idx_i,
  input  logic [NUM_FINGERS*CNT_W-1:0] cnt_flat_i,
  output logic [CNT_W-1:0]             rd_data_o
);
  logic [CNT_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_FINGERS; k++) begin
      if (int'(rd_idx_i) == k) sel = cnt_flat_i[k*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_data_o <= '0;
    else if (done_i) rd_data_o <= sel;
    else             rd_data_o <= '0;
  end
endmodule

// File: rtl/rake_chan_est.sv
module rake_chan_est #(
  parameter int NUM_FINGERS = 64,
  parameter int CNT_W       = 7,
  parameter int PULSE_CNT_W = 11,
  localparam int IDX_W      = (NUM_FINGERS > 1) ? $clog2(NUM_FINGERS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [PULSE_CNT_W-1:0] num_pulses_i,
  input  logic                   pulse_valid_i,
  input  logic [NUM_FINGERS-1:0] samples_i,
  input  logic                   polarity_i,
  output logic                   done_o,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output logic [CNT_W-1:0]       rd_data_o
);
  logic                         upd;
  logic                         busy;
  logic [NUM_FINGERS*CNT_W-1:0] cnt_flat;

  rake_seq #(.PULSE_CNT_W(PULSE_CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .num_pulses_i (num_pulses_i),
    .pulse_valid_i(pulse_valid_i),
    .upd_o        (upd),
    .busy_o       (busy),
    .done_o       (done_o)
  );

  for (genvar g = 0; g < NUM_FINGERS; g++) begin : g_finger
    rake_finger #(.CNT_W(CNT_W)) u_finger (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .en_i  (upd),
      .down_i(samples_i[g] ^ polarity_i),
      .cnt_o (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  rake_readout #(
    .NUM_FINGERS(NUM_FINGERS),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) u_readout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done_o),
    .rd_idx_i  (rd_idx_i),
    .cnt_flat_i(cnt_flat),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/rake_chan_est_chk.sv
module rake_chan_est_chk #(
  parameter int CNT_W       = 7,
  parameter int PULSE_CNT_W = 11,
  parameter int IDX_W       = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [PULSE_CNT_W-1:0] num_pulses_i,
  input logic                   pulse_valid_i,
  input logic                   sample0_i,
  input logic                   polarity_i,
  input logic                   done_o,
  input logic [IDX_W-1:0]       rd_idx_i,
  input logic [CNT_W-1:0]       rd_data_o,
  input logic                   busy_i,
  input logic [CNT_W-1:0]       cnt0_i
);
  localparam logic [CNT_W-1:0] CntMax = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CntMin = {1'b1, {(CNT_W-1){1'b0}}};

  p_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (num_pulses_i != '0) |=> !done_o && (cnt0_i == '0));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt0_i == CntMax) && !start_i |=> (cnt0_i == CntMax) || (cnt0_i == CntMax - 1'b1));

  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt0_i == CntMin) && !start_i |=> (cnt0_i == CntMin) || (cnt0_i == CntMin + 1'b1));

  p_step_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && pulse_valid_i && !start_i && (sample0_i == polarity_i) && (cnt0_i != CntMax)
    |=> cnt0_i == $past(cnt0_i) + 1'b1);

  p_step_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && pulse_valid_i && !start_i && (sample0_i != polarity_i) && (cnt0_i != CntMin)
    |=> cnt0_i == $past(cnt0_i) - 1'b1);

  p_done_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(done_o) && !$past(start_i) && $stable(rd_idx_i) |=> $stable(rd_data_o));

  p_rd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> rd_data_o == '0);
endmodule

bind rake_chan_est rake_chan_est_chk #(
  .CNT_W      (CNT_W),
  .PULSE_CNT_W(PULSE_CNT_W),
  .IDX_W      (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .num_pulses_i (num_pulses_i),
  .pulse_valid_i(pulse_valid_i),
  .sample0_i    (samples_i[0]),
  .polarity_i   (polarity_i),
  .done_o       (done_o),
  .rd_idx_i     (rd_idx_i),
  .rd_data_o    (rd_data_o),
  .busy_i       (busy),
  .cnt0_i       (cnt_flat[CNT_W-1:0])
);

// File: tb/rake_chan_est_bench.sv
module rake_chan_est_bench;
  localparam int NF = 64;
  localparam int CW = 7;
  localparam int PW = 11;
  localparam int IW = 6;
  localparam int NVEC = 6;
  localparam logic [NF:0] VEC_TBL [NVEC] = '{
    {1'b0, 64'h0000_0000_0000_0000},
    {1'b0, 64'hFFFF_0000_FFFF_0000},
    {1'b1, 64'hF0F0_F0F0_0F0F_0F0F},
    {1'b1, 64'h0000_0000_FFFF_FFFF},
    {1'b0, 64'hAAAA_5555_AAAA_5555},
    {1'b1, 64'h1234_5678_9ABC_DEF0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [PW-1:0] num_pulses_i = '0;
  logic          pulse_valid_i = 1'b0;
  logic [NF-1:0] samples_i = '0;
  logic          polarity_i = 1'b0;
  logic          done_o;
  logic [IW-1:0] rd_idx_i = '0;
  logic [CW-1:0] rd_data_o;

  int n_checks = 0;
  int n_fails  = 0;
  int model [NF];

  always #10 clk_i = ~clk_i;

  rake_chan_est #(.NUM_FINGERS(NF), .CNT_W(CW), .PULSE_CNT_W(PW)) u_rake_chan_est (
    .clk_i, .rst_ni, .start_i, .num_pulses_i, .pulse_valid_i,
    .samples_i, .polarity_i, .done_o, .rd_idx_i, .rd_data_o
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [NF-1:0] s, input logic p);
    for (int k = 0; k < NF; k++) begin
      if (s[k] ^ p) model[k] = (model[k] > -64) ? model[k] - 1 : -64;
      else          model[k] = (model[k] < 63)  ? model[k] + 1 : 63;
    end
  endtask

  task automatic pulse(input logic [NF-1:0] s, input logic p, input bit acc);
    @(negedge clk_i);
    pulse_valid_i = 1'b1; samples_i = s; polarity_i = p;
    @(negedge clk_i);
    pulse_valid_i = 1'b0; samples_i = ~s;  // idle cycle with changed samples
    if (acc) model_step(s, p);
  endtask

  task automatic do_start(input int n, input bit with_pulse);
    @(negedge clk_i);
    start_i = 1'b1; num_pulses_i = PW'(n);
    pulse_valid_i = with_pulse; samples_i = '0; polarity_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0; pulse_valid_i = 1'b0;
    for (int k = 0; k < NF; k++) model[k] = 0;
  endtask

  task automatic read_check(input string tag, input int k, input int exp);
    @(negedge clk_i);
    rd_idx_i = IW'(k);
    @(negedge clk_i);
    check(tag, int'($signed(rd_data_o)), exp);
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < NF; k++) read_check(tag, k, model[k]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NF; k++) model[k] = 0;
    #35 rst_ni = 1'b1;
    // R1: reset state
    @(negedge clk_i);
    check("R1 done_o", int'(done_o), 0);
    check("R1 rd_data_o", int'(rd_data_o), 0);
    // R6: pulses before any start are ignored
    pulse('0, 1'b0, 1'b0);
    // R7: read while not done returns zero
    read_check("R7 read_idle", 3, 0);
    // R5: zero count gives done on edge after start; R1 fingers still zero
    do_start(0, 1'b0);
    check("R5 done_zero_count", int'(done_o), 1);
    read_check("R1 finger0", 0, 0);
    read_check("R1 finger63", 63, 0);

    // R4: table walk, then R5 done timing
    do_start(NVEC, 1'b0);
    check("R2 done_cleared", int'(done_o), 0);
    for (int i = 0; i < NVEC; i++) begin
      if (i == NVEC - 1) check("R5 done_before_last", int'(done_o), 0);
      pulse(VEC_TBL[i][NF-1:0], VEC_TBL[i][NF], 1'b1);
    end
    check("R5 done_after_last", int'(done_o), 1);
    read_all("R4 table");

    // R6: pulses after done are blocked
    pulse('0, 1'b0, 1'b0);
    pulse('1, 1'b0, 1'b0);
    pulse('0, 1'b1, 1'b0);
    check("R6 done_held", int'(done_o), 1);
    for (int k = 0; k < 8; k++) read_check("R6 frozen", k, model[k]);

    // R3: saturation high then low
    do_start(100, 1'b0);
    for (int i = 0; i < 100; i++) pulse('0, 1'b0, 1'b1);
    read_check("R3 sat_hi0", 0, 63);
    read_check("R3 sat_hi63", 63, 63);
    do_start(100, 1'b0);
    for (int i = 0; i < 100; i++) pulse('1, 1'b0, 1'b1);
    read_check("R3 sat_lo0", 0, -64);
    read_check("R3 sat_lo40", 40, -64);

    // R2: restart mid run with a coincident pulse that must be dropped
    do_start(4, 1'b0);
    pulse('0, 1'b0, 1'b1);
    pulse('0, 1'b0, 1'b1);
    do_start(2, 1'b1);
    check("R2 done_low_after_restart", int'(done_o), 0);
    pulse(64'h0000_0000_0000_00FF, 1'b1, 1'b1);
    check("R5 done_mid", int'(done_o), 0);
    pulse(64'h0000_0000_0000_000F, 1'b1, 1'b1);
    check("R5 done_two", int'(done_o), 1);
    read_all("R2 restart");

    finish_run();
  end
endmodule